// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Watchdog

This block holds a free-running up-counter advanced from the bus clock through a prescaler. A 2-bit speed code picks one of four divide ratios. The divider chain that feeds the prescaler also provides a fixed power-of-two tap. That tap clocks a watchdog, which asks for a system reset unless software completes a two-write service sequence before a selectable number of tap periods has passed. When the counter wraps it sets a sticky overflow flag, and software clears the flag with a write-one strobe.

A control state machine steps through three states. SETUP is a short window after reset in which the speed code and the watchdog limit code are sampled. RUN is the state in which the counter, the divider chain and the watchdog advance. HOLD is the state in which the reset request is driven low for a fixed time. The transitions are SETUP to RUN when the window ends, RUN to HOLD on watchdog expiry, and HOLD to SETUP when the hold time ends. A second state machine tracks the service sequence with two states. IDLE moves to ARMED on a write of 0x55. ARMED moves back to IDLE on a write of 0xAA, which completes the service, or on a write of any other value. A further write of 0x55 keeps it in ARMED. Outside RUN the service machine is held in IDLE.

Top module: `prescaled_wdt_timer`

## Requirements
- R1: While `rst_n` is low and right after its release, `cnt_o` is 0, `ovf_o` is 0 and `rst_req_n_o` is 1.
- R2: During the SETUP_CYC clock edges that follow reset (or the end of a hold), the counter stays at 0 and `rate_i` and `wd_rate_i` are sampled on each edge. The values present at the last window edge take effect. Later changes of either input are ignored until the next window.
- R3: The speed code in RUN gives one counter increment per 1 clock for 00, per 4 clocks for 01, per 8 clocks for 10 and per 16 clocks for 11. After n RUN edges, `cnt_o` equals floor(n/P) modulo 2^CNT_W.
- R4: When the counter steps from all ones to 0, `ovf_o` goes to 1 on that same edge.
- R5: A high `ovf_clr_i` clears `ovf_o` on the next edge. If a wrap happens on that same edge, the flag stays set.
- R6: The watchdog sees one tick every 2^TAP_LOG2 RUN edges. Without service it expires on the 2^k-th tick, where k is the sampled `wd_rate_i` (00 gives 1 tick, 01 gives 2, 10 gives 4, 11 gives 8), and `rst_req_n_o` goes low after that edge.
- R7: Service is a write (`svc_we_i` high) of 0x55 followed by a write of 0xAA, with any number of idle cycles allowed between them. Only the completed pair restarts the tick count, and it takes priority over a tick on the same edge. A write of any other value between the two writes cancels the sequence.
- R8: `rst_req_n_o` stays low for exactly HOLD_CYC cycles. During that time the counter, the flag and the watchdog are cleared. The block then reopens the setup window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock E |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_i | input | 2 | Counter speed code, sampled in SETUP |
| wd_rate_i | input | 2 | Watchdog limit code, sampled in SETUP |
| svc_we_i | input | 1 | Service register write strobe |
| svc_data_i | input | 8 | Service register write data |
| ovf_clr_i | input | 1 | Write-one clear of the overflow flag |
| cnt_o | output | CNT_W | Free-running counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| rst_req_n_o | output | 1 | Active-low reset request |

## Verification
Every result is registered once. The counter, the overflow flag and the reset request all show the effect of an edge immediately after that edge. A timeout shows up at the same edge as the expiring tick, and the reset request returns HOLD_CYC edges later. The bench drives inputs and samples outputs 1 ns after each rising edge. Before each edge it advances its own expected state once, from the inputs it has just driven, so that every comparison lines up with the edge that produced it. Directed checks pick the exact edge of the wrap, the clear collision, the tick that expires and the tick that has just been serviced.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_SETUP = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2
    } tmr_state_e;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W    = 15,
    parameter int TAP_LOG2 = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate_sel,
    output logic       cnt_tick,
    output logic       wd_tick
);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        unique case (rate_sel)
            2'b00:   cnt_tick = run;
            2'b01:   cnt_tick = run && (&div_q[1:0]);
            2'b10:   cnt_tick = run && (&div_q[2:0]);
            default: cnt_tick = run && (&div_q[3:0]);
        endcase
    end

    assign wd_tick = run && (&div_q[TAP_LOG2-1:0]);

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    logic at_top;
    assign at_top = &cnt_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (!run) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else begin
            if (tick) begin
                cnt_o <= cnt_o + 1'b1;
            end
            if (tick && at_top) begin
                ovf_o <= 1'b1;
            end else if (ovf_clr) begin
                ovf_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_svc.sv
module tmr_svc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       we,
    input  logic [7:0] data,
    output logic       done
);
    import tmr_pkg::*;

    svc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = SVC_IDLE;
        end else if (we) begin
            unique case (state_q)
                SVC_IDLE:  state_d = (data == KEY_ARM) ? SVC_ARMED : SVC_IDLE;
                SVC_ARMED: state_d = (data == KEY_ARM) ? SVC_ARMED : SVC_IDLE;
                default:   state_d = SVC_IDLE;
            endcase
        end
    end

    always_comb begin
        done = run && we && (state_q == SVC_ARMED) && (data == KEY_FIRE);
    end

endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog #(
    parameter int WD_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       clear,
    input  logic [1:0] limit_sel,
    output logic       expire
);

    logic [WD_W-1:0] wd_q;
    logic [WD_W-1:0] last_val;

    always_comb begin
        last_val = (WD_W'(1) << limit_sel) - WD_W'(1);
        expire   = run && tick && !clear && (wd_q == last_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else if (!run || clear) begin
            wd_q <= '0;
        end else if (tick) begin
            wd_q <= wd_q + 1'b1;
        end
    end

endmodule

// File: rtl/prescaled_wdt_timer.sv
module prescaled_wdt_timer #(
    parameter int CNT_W     = 16,
    parameter int TAP_LOG2  = 15,
    parameter int SETUP_CYC = 8,
    parameter int HOLD_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_i,
    input  logic [1:0]       wd_rate_i,
    input  logic             svc_we_i,
    input  logic [7:0]       svc_data_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             rst_req_n_o
);
    import tmr_pkg::*;

    localparam int DIV_W  = (TAP_LOG2 > 4) ? TAP_LOG2 : 4;
    localparam int WIN_W  = $clog2(SETUP_CYC + 1);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam int WD_W   = 4;

    tmr_state_e       state_q, state_d;
    logic [WIN_W-1:0]  win_q;
    logic [HOLD_W-1:0] hold_q;
    logic [1:0]        rate_q, wdr_q;
    logic              run, capture;
    logic              cnt_tick, wd_tick, svc_done, wd_expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETUP: if (win_q == WIN_W'(SETUP_CYC - 1)) state_d = ST_RUN;
            ST_RUN:   if (wd_expire) state_d = ST_HOLD;
            ST_HOLD:  if (hold_q == HOLD_W'(HOLD_CYC - 1)) state_d = ST_SETUP;
            default:  state_d = ST_SETUP;
        endcase
    end

    always_comb begin
        run         = (state_q == ST_RUN);
        capture     = (state_q == ST_SETUP);
        rst_req_n_o = (state_q != ST_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            hold_q <= '0;
            rate_q <= 2'b00;
            wdr_q  <= 2'b00;
        end else begin
            win_q  <= capture ? win_q + 1'b1 : '0;
            hold_q <= (state_q == ST_HOLD) ? hold_q + 1'b1 : '0;
            if (capture) begin
                rate_q <= rate_i;
                wdr_q  <= wd_rate_i;
            end
        end
    end

    tmr_prescale #(.DIV_W(DIV_W), .TAP_LOG2(TAP_LOG2)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rate_sel (rate_q),
        .cnt_tick (cnt_tick),
        .wd_tick  (wd_tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (cnt_tick),
        .ovf_clr (ovf_clr_i),
        .cnt_o   (cnt_o),
        .ovf_o   (ovf_o)
    );

    tmr_svc u_svc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .we    (svc_we_i),
        .data  (svc_data_i),
        .done  (svc_done)
    );

    tmr_wdog #(.WD_W(WD_W)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (wd_tick),
        .clear     (svc_done),
        .limit_sel (wdr_q),
        .expire    (wd_expire)
    );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CNT_W    = 16,
    parameter int HOLD_CYC = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CNT_W-1:0]       cnt_o,
    input logic                   ovf_o,
    input logic                   ovf_clr_i,
    input logic                   rst_req_n_o,
    input tmr_pkg::tmr_state_e    state_q,
    input logic [1:0]             rate_q,
    input logic [1:0]             wdr_q
);
    import tmr_pkg::*;

    logic [15:0] low_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len <= '0;
        end else if (!rst_req_n_o) begin
            low_len <= low_len + 1'b1;
        end else begin
            low_len <= '0;
        end
    end

    // R8
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_n_o) |-> (low_len == 16'(HOLD_CYC)));

    // R8
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_n_o |=> (cnt_o == '0 && !ovf_o));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_n_o && $past(rst_req_n_o)) |->
        (cnt_o == $past(cnt_o) || cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

    // R4
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (cnt_o == '0));

    // R5
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && ovf_clr_i && cnt_o != '1) |=> !ovf_o);

    // R2
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN) |->
        ($stable(rate_q) && $stable(wdr_q)));

endmodule

bind prescaled_wdt_timer tmr_chk #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_o       (cnt_o),
    .ovf_o       (ovf_o),
    .ovf_clr_i   (ovf_clr_i),
    .rst_req_n_o (rst_req_n_o),
    .state_q     (state_q),
    .rate_q      (rate_q),
    .wdr_q       (wdr_q)
);

// File: tb/tb_prescaled_wdt_timer.sv
`timescale 1ns/1ps
module tb_prescaled_wdt_timer;

    localparam int CW    = 8;
    localparam int TAP   = 8;
    localparam int SETUP = 8;
    localparam int HOLD  = 4;
    localparam int M     = 1 << CW;
    localparam int T     = 1 << TAP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    rate_i = 2'b00;
    logic [1:0]    wd_rate_i = 2'b00;
    logic          svc_we_i = 1'b0;
    logic [7:0]    svc_data_i = 8'h00;
    logic          ovf_clr_i = 1'b0;
    logic [CW-1:0] cnt_o;
    logic          ovf_o;
    logic          rst_req_n_o;

    int checks = 0;
    int fails  = 0;

    int m_ph, m_e, m_n, m_s, m_h, m_cnt;
    int m_psel, m_wsel;
    bit m_ovf, m_arm;

    always #2 clk = ~clk;

    prescaled_wdt_timer #(.CNT_W(CW), .TAP_LOG2(TAP), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .rate_i(rate_i), .wd_rate_i(wd_rate_i),
        .svc_we_i(svc_we_i), .svc_data_i(svc_data_i), .ovf_clr_i(ovf_clr_i),
        .cnt_o(cnt_o), .ovf_o(ovf_o), .rst_req_n_o(rst_req_n_o)
    );

    function automatic int period_of(int sel);
        return (sel == 0) ? 1 : (1 << (sel + 1));
    endfunction

    function automatic int limit_of(int sel);
        return 1 << sel;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        int p;
        case (m_ph)
            0: begin
                m_psel = int'(rate_i);
                m_wsel = int'(wd_rate_i);
                m_e++;
                m_cnt = 0;
                m_ovf = 0;
                if (m_e == SETUP) begin
                    m_ph = 1; m_n = 0; m_s = 0; m_arm = 0;
                end
            end
            1: begin
                m_n++;
                p = period_of(m_psel);
                m_cnt = (m_n / p) % M;
                if (m_n % (p * M) == 0) m_ovf = 1;
                else if (ovf_clr_i) m_ovf = 0;
                if (svc_we_i) begin
                    if (m_arm && svc_data_i == 8'hAA) m_s = m_n;
                    m_arm = (svc_data_i == 8'h55);
                end
                if ((m_n / T - m_s / T) >= limit_of(m_wsel)) begin
                    m_ph = 2; m_h = 0;
                end
            end
            default: begin
                m_h++;
                m_cnt = 0;
                m_ovf = 0;
                if (m_h == HOLD) begin
                    m_ph = 0; m_e = 0;
                end
            end
        endcase
    endtask

    task automatic compare();
        string ct;
        ct = (m_ph == 0) ? "R2 cnt" : (m_ph == 1) ? "R3 cnt" : "R8 cnt";
        chk(int'(cnt_o) == m_cnt, ct, int'(cnt_o), m_cnt);
        chk(ovf_o == m_ovf, "R4/R5 ovf", int'(ovf_o), int'(m_ovf));
        chk(rst_req_n_o == (m_ph != 2), "R6/R8 rst_req_n", int'(rst_req_n_o), int'(m_ph != 2));
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic do_reset(logic [1:0] r, logic [1:0] w);
        rst_n = 1'b0;
        rate_i = r; wd_rate_i = w;
        svc_we_i = 0; ovf_clr_i = 0;
        m_ph = 0; m_e = 0; m_cnt = 0; m_ovf = 0; m_arm = 0; m_n = 0; m_s = 0;
        repeat (2) @(posedge clk);
        #1;
        // R1 during reset
        chk(cnt_o == '0 && !ovf_o && rst_req_n_o, "R1 in reset", int'(cnt_o), 0);
        rst_n = 1'b1;
        #1;
        // R1 after release
        chk(cnt_o == '0 && !ovf_o && rst_req_n_o, "R1 after release", int'(cnt_o), 0);
    endtask

    task automatic run_to(int target);
        while (m_ph == 1 && m_n < target) step();
        while (m_ph == 0) step();
        while (m_ph == 1 && m_n < target) step();
    endtask

    task automatic svc(logic [7:0] d);
        svc_we_i = 1'b1; svc_data_i = d;
        step();
        svc_we_i = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));

        // R2: window captures the value present at its final edge
        do_reset(2'b00, 2'b00);
        for (int i = 0; i < SETUP - 1; i++) step();
        rate_i = 2'b10; wd_rate_i = 2'b11;
        step();
        rate_i = 2'b11; wd_rate_i = 2'b00;
        run_to(80);
        chk(int'(cnt_o) == 10, "R2 rate from last window edge", int'(cnt_o), 10);
        run_to(600);
        chk(rst_req_n_o == 1'b1, "R2 late wd_rate ignored", int'(rst_req_n_o), 1);

        // R3: each speed code
        for (int sel = 0; sel < 4; sel++) begin
            do_reset(sel[1:0], 2'b11);
            run_to(160);
            chk(int'(cnt_o) == 160 / period_of(sel), "R3 speed code", int'(cnt_o), 160 / period_of(sel));
        end

        // R4 / R5
        do_reset(2'b00, 2'b11);
        run_to(256);
        chk(ovf_o && cnt_o == '0, "R4 wrap sets flag", int'(ovf_o), 1);
        ovf_clr_i = 1'b1; step(); ovf_clr_i = 1'b0;
        chk(!ovf_o, "R5 clear", int'(ovf_o), 0);
        run_to(511);
        ovf_clr_i = 1'b1; step(); ovf_clr_i = 1'b0;
        chk(ovf_o == 1'b1, "R5 wrap wins over clear", int'(ovf_o), 1);

        // R6 / R8: one-tick limit
        do_reset(2'b00, 2'b00);
        run_to(255);
        chk(rst_req_n_o == 1'b1, "R6 before tick", int'(rst_req_n_o), 1);
        step();
        chk(rst_req_n_o == 1'b0, "R6 expire on first tick", int'(rst_req_n_o), 0);
        repeat (HOLD - 1) step();
        chk(rst_req_n_o == 1'b0, "R8 still held", int'(rst_req_n_o), 0);
        step();
        chk(rst_req_n_o == 1'b1 && cnt_o == '0, "R8 release after hold", int'(rst_req_n_o), 1);

        // R6: four-tick limit
        do_reset(2'b01, 2'b10);
        run_to(1023);
        chk(rst_req_n_o == 1'b1, "R6 four ticks not yet", int'(rst_req_n_o), 1);
        step();
        chk(rst_req_n_o == 1'b0, "R6 expire on fourth tick", int'(rst_req_n_o), 0);

        // R7: valid pair with idle gap postpones expiry
        do_reset(2'b00, 2'b01);
        run_to(300);
        svc(8'h55);
        repeat (3) step();
        svc(8'hAA);
        run_to(767);
        chk(rst_req_n_o == 1'b1, "R7 serviced survives 512", int'(rst_req_n_o), 1);
        step();
        chk(rst_req_n_o == 1'b0, "R7 expire two ticks after service", int'(rst_req_n_o), 0);

        // R7: interrupted pair does not service
        do_reset(2'b00, 2'b01);
        run_to(300);
        svc(8'h55); svc(8'h12); svc(8'hAA);
        run_to(511);
        step();
        chk(rst_req_n_o == 1'b0, "R7 broken pair ignored", int'(rst_req_n_o), 0);

        // R7: service on a tick edge wins
        do_reset(2'b00, 2'b00);
        run_to(254);
        svc(8'h55); svc(8'hAA);
        chk(rst_req_n_o == 1'b1, "R7 service beats tick", int'(rst_req_n_o), 1);

        // constrained random mix
        for (int r = 0; r < 4; r++) begin
            do_reset(2'($urandom_range(0, 3)), 2'($urandom_range(1, 3)));
            for (int c = 0; c < 2500; c++) begin
                int pick;
                svc_we_i  = ($urandom_range(0, 99) < 15);
                pick      = $urandom_range(0, 9);
                svc_data_i = (pick < 4) ? 8'h55 : (pick < 8) ? 8'hAA : 8'($urandom_range(0, 255));
                ovf_clr_i = ($urandom_range(0, 99) < 3);
                if ($urandom_range(0, 99) < 2) rate_i = 2'($urandom_range(0, 3));
                step();
            end
            svc_we_i = 0; ovf_clr_i = 0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule